// File: doc/BRIEF.md
# Digital Potentiometer Wiper and Stored-Setting Bank

This block keeps the live position of a 1024-step digital potentiometer and four stored settings. A command decoder sits in front of it and issues single-word commands. The block answers read commands with a response word. It also drives a one-hot tap-select bus that picks exactly one switch on the resistor ladder.

The stored settings model cells that need a slow programming cycle. They are held in flops, and a cycle counter stands in for the programming time. While a programming cycle runs, a busy flag is high. A store waits in a staging register and reaches its setting only when the busy window ends. A hardware enable pin can refuse stores outright.

Changes to the live position are visible to reads at once. The tap bus follows only after a response delay, which imitates the settling time of the analog switches. When reset is released, the block copies setting 0 into the live position and onto the tap bus.

Commands use a valid/ready handshake. The block drops `cmd_ready` while a response is waiting or while the power-up recall is in progress. A response stays on `rsp_valid`/`rsp_data` without change until the consumer raises `rsp_ready`. Every accepted command is consumed in one cycle.

Top module: `potreg_bank`

## Requirements
- R1: In the first cycle after reset is released, setting 0 (reset value `BOOT_VAL`) is copied into the live position and onto the tap bus. `cmd_ready` stays low during that cycle.
- R2: Opcode 1 (set position) loads `cmd_data` into the live position. A later opcode 0 (get position) returns the new value, even before the tap bus has moved. The full opcode set is: 0 get position, 1 set position, 2 get setting, 3 put setting, 4 setting to position, 5 position to setting, 6 get busy.
- R3: After opcode 1 or 4 is accepted, the tap bus keeps its old position for exactly `WDLY` cycles and then shows the new one. A second position load inside that window restarts the window, and only the latest value appears.
- R4: Opcode 4 copies all 10 bits of the setting selected by `cmd_sel` (0 to 3) into the live position. Opcode 5 stores all 10 bits of the live position into the selected setting.
- R5: Opcode 3 (store `cmd_data`) or opcode 5 raises `nv_busy` in the cycle after acceptance and keeps it high for exactly `NV_CYCLES` cycles. The setting takes its new value when `nv_busy` falls. A read accepted in the last busy cycle still returns the old value.
- R6: While `store_en` is low, opcodes 3 and 5 are discarded. `nv_busy` stays low and the settings keep their values.
- R7: A store accepted while `nv_busy` is high is discarded. This includes a store in the final busy cycle. It does not change any setting and does not lengthen the busy window.
- R8: While `nv_busy` is high, reads and position loads are still served normally. A read of a setting returns its value from before the store.
- R9: The tap bus always has exactly one bit set, at the index equal to the displayed position. Position 000h drives bit 0 and 3FFh drives bit 1023.
- R10: Opcode 6 returns a word with bit 0 equal to `nv_busy` and all other bits zero.
- R11: After a read is accepted, `rsp_valid` rises on the next cycle. While `rsp_ready` is low, `rsp_valid` and `rsp_data` stay unchanged and `cmd_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_sel | input | 2 | Stored-setting index |
| cmd_data | input | 10 | Write value |
| rsp_valid | output | 1 | Read response held |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 10 | Read response value |
| store_en | input | 1 | High allows stores into the settings |
| nv_busy | output | 1 | Programming cycle in progress |
| tap_sel | output | 1024 | One-hot tap select |

## Verification
The critical overlap is the busy window's commit edge. In that same cycle the staged value lands in its setting, and a new command can be accepted. The bench issues a store, counts exactly `NV_CYCLES - 1` further cycles, and then places a read of the same setting on the commit edge. The read must return the old value, and a read right after must return the new one. A second run puts another store on the commit edge instead. That store must leave no trace: `nv_busy` is low one cycle later, and the setting holds the first value.

// File: rtl/potreg_pkg.sv
package potreg_pkg;
  typedef enum logic [2:0] {
    OP_GET_WIPER     = 3'd0,
    OP_SET_WIPER     = 3'd1,
    OP_GET_SLOT      = 3'd2,
    OP_PUT_SLOT      = 3'd3,
    OP_SLOT_TO_WIPER = 3'd4,
    OP_WIPER_TO_SLOT = 3'd5,
    OP_GET_BUSY      = 3'd6
  } pot_op_e;
endpackage

// File: rtl/potreg_slots.sv
module potreg_slots #(
  parameter int DW        = 10,
  parameter int NREG      = 4,
  parameter int NV_CYCLES = 1000000,
  parameter logic [DW-1:0] BOOT_VAL = '0,
  localparam int SW   = $clog2(NREG),
  localparam int NV_W = $clog2(NV_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          store_req,
  input  logic [SW-1:0] store_sel,
  input  logic [DW-1:0] store_val,
  input  logic          store_en,
  input  logic [SW-1:0] rd_sel,
  output logic [DW-1:0] rd_val,
  output logic [DW-1:0] boot_val,
  output logic          busy
);
  logic               busy_q;
  logic [NV_W-1:0]    cnt_q;
  logic [SW-1:0]      stage_sel_q;
  logic [DW-1:0]      stage_val_q;
  logic [NREG*DW-1:0] slot_flat;
  logic               start;
  logic               commit;

  assign start  = store_req && store_en && !busy_q;
  assign commit = busy_q && (cnt_q == NV_W'(0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      stage_sel_q <= '0;
      stage_val_q <= '0;
    end else if (start) begin
      busy_q      <= 1'b1;
      cnt_q       <= NV_W'(NV_CYCLES - 1);
      stage_sel_q <= store_sel;
      stage_val_q <= store_val;
    end else if (commit) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - NV_W'(1);
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic [DW-1:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        val_q <= (g == 0) ? BOOT_VAL : '0;
      else if (commit && (stage_sel_q == SW'(g)))
        val_q <= stage_val_q;
    end
    assign slot_flat[g*DW +: DW] = val_q;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_sel == SW'(i)) rd_val = slot_flat[i*DW +: DW];
  end

  assign boot_val = slot_flat[DW-1:0];
  assign busy     = busy_q;

  // R6
  protect_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req && !store_en && !busy_q) |=> !busy_q);
  // R7
  busy_stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && store_req) |=> ($stable(stage_val_q) && $stable(stage_sel_q)));
  // R5
  slots_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(slot_flat));
endmodule

// File: rtl/potreg_wiper.sv
module potreg_wiper #(
  parameter int DW   = 10,
  parameter int WDLY = 1000,
  localparam int DL_W = $clog2(WDLY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] boot_val,
  input  logic          load_req,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] wpos,
  output logic [DW-1:0] tap_pos,
  output logic          recalling
);
  logic [DW-1:0]   wpos_q;
  logic [DW-1:0]   tap_q;
  logic            pend_q;
  logic [DL_W-1:0] dcnt_q;
  logic            recall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpos_q   <= '0;
      tap_q    <= '0;
      pend_q   <= 1'b0;
      dcnt_q   <= '0;
      recall_q <= 1'b1;
    end else if (recall_q) begin
      wpos_q   <= boot_val;
      tap_q    <= boot_val;
      recall_q <= 1'b0;
    end else if (load_req) begin
      wpos_q <= load_val;
      pend_q <= 1'b1;
      dcnt_q <= DL_W'(WDLY - 1);
    end else if (pend_q) begin
      if (dcnt_q == DL_W'(0)) begin
        tap_q  <= wpos_q;
        pend_q <= 1'b0;
      end else begin
        dcnt_q <= dcnt_q - DL_W'(1);
      end
    end
  end

  assign wpos      = wpos_q;
  assign tap_pos   = tap_q;
  assign recalling = recall_q;

  // R2
  load_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> (wpos_q == $past(load_val)));
  // R3
  tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(pend_q) && !$past(recall_q)) |-> $stable(tap_q));
endmodule

// File: rtl/potreg_tapdec.sv
module potreg_tapdec #(
  parameter int DW = 10,
  localparam int TAPS = 1 << DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   pos,
  output logic [TAPS-1:0] sel
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign sel[i] = (pos == DW'(i));
  end

  // R9
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel) == 1);
  // R9
  tap_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == '0) |-> (sel[0] && !sel[TAPS-1]));
endmodule

// File: rtl/potreg_bank.sv
module potreg_bank
  import potreg_pkg::*;
#(
  parameter int DW        = 10,
  parameter int NREG      = 4,
  parameter int NV_CYCLES = 1000000,
  parameter int WDLY      = 1000,
  parameter logic [DW-1:0] BOOT_VAL = 10'h200,
  localparam int SW   = $clog2(NREG),
  localparam int TAPS = 1 << DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [SW-1:0]   cmd_sel,
  input  logic [DW-1:0]   cmd_data,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [DW-1:0]   rsp_data,
  input  logic            store_en,
  output logic            nv_busy,
  output logic [TAPS-1:0] tap_sel
);
  pot_op_e       op;
  logic          accept;
  logic          load_req;
  logic [DW-1:0] load_val;
  logic          store_req;
  logic [DW-1:0] store_val;
  logic [DW-1:0] slot_val;
  logic [DW-1:0] boot_val;
  logic [DW-1:0] wpos;
  logic [DW-1:0] tap_pos;
  logic          recalling;
  logic          rsp_valid_q;
  logic [DW-1:0] rsp_data_q;

  assign op        = pot_op_e'(cmd_op);
  assign cmd_ready = !rsp_valid_q && !recalling;
  assign accept    = cmd_valid && cmd_ready;

  assign load_req  = accept && (op == OP_SET_WIPER || op == OP_SLOT_TO_WIPER);
  assign load_val  = (op == OP_SET_WIPER) ? cmd_data : slot_val;
  assign store_req = accept && (op == OP_PUT_SLOT || op == OP_WIPER_TO_SLOT);
  assign store_val = (op == OP_PUT_SLOT) ? cmd_data : wpos;

  potreg_slots #(
    .DW(DW), .NREG(NREG), .NV_CYCLES(NV_CYCLES), .BOOT_VAL(BOOT_VAL)
  ) u_slots (
    .clk(clk), .rst_n(rst_n),
    .store_req(store_req), .store_sel(cmd_sel), .store_val(store_val),
    .store_en(store_en), .rd_sel(cmd_sel), .rd_val(slot_val),
    .boot_val(boot_val), .busy(nv_busy)
  );

  potreg_wiper #(.DW(DW), .WDLY(WDLY)) u_wiper (
    .clk(clk), .rst_n(rst_n), .boot_val(boot_val),
    .load_req(load_req), .load_val(load_val),
    .wpos(wpos), .tap_pos(tap_pos), .recalling(recalling)
  );

  potreg_tapdec #(.DW(DW)) u_tapdec (
    .clk(clk), .rst_n(rst_n), .pos(tap_pos), .sel(tap_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept) begin
      case (op)
        OP_GET_WIPER: begin rsp_valid_q <= 1'b1; rsp_data_q <= wpos; end
        OP_GET_SLOT:  begin rsp_valid_q <= 1'b1; rsp_data_q <= slot_val; end
        OP_GET_BUSY:  begin rsp_valid_q <= 1'b1; rsp_data_q <= {{(DW-1){1'b0}}, nv_busy}; end
        default: ;
      endcase
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R11
  no_accept_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);
  // R1
  recall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recalling |-> !cmd_ready);
endmodule

// File: tb/potreg_bank_bench.sv
module potreg_bank_bench;
  localparam int NV = 20;
  localparam int WD = 6;
  localparam logic [9:0] BOOT = 10'h155;

  logic clk = 0;
  logic rst_n = 0;
  logic cmd_valid = 0;
  logic cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_sel = '0;
  logic [9:0] cmd_data = '0;
  logic rsp_valid;
  logic rsp_ready = 0;
  logic [9:0] rsp_data;
  logic store_en = 1;
  logic nv_busy;
  logic [1023:0] tap_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [9:0] m_slot [4];
  logic [9:0] m_wpos;

  always #5 clk = ~clk;

  potreg_bank #(.NV_CYCLES(NV), .WDLY(WD), .BOOT_VAL(BOOT)) u_potreg_bank (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .store_en(store_en), .nv_busy(nv_busy), .tap_sel(tap_sel)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] model_read(input logic [2:0] op, input logic [1:0] sel);
    case (op)
      3'd0: return m_wpos;
      3'd2: return m_slot[sel];
      default: return 10'h000;
    endcase
  endfunction

  function automatic bit tap_at(input logic [9:0] p);
    return tap_sel[p] && ($countones(tap_sel) == 1);
  endfunction

  task automatic issue(input logic [2:0] op, input logic [1:0] sel, input logic [9:0] d);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_sel = sel; cmd_data = d;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic fetch(input logic [2:0] op, input logic [1:0] sel, output logic [9:0] v);
    issue(op, sel, '0);
    check(rsp_valid === 1'b1, "R11 response valid", rsp_valid, 1);
    v = rsp_data;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic wait_idle();
    while (nv_busy) @(negedge clk);
  endtask

  initial begin
    logic [9:0] v;
    int cnt;
    for (int i = 0; i < 4; i++) m_slot[i] = (i == 0) ? BOOT : 10'h000;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!nv_busy && !rsp_valid && tap_sel[0], "R1 reset state", {nv_busy, rsp_valid}, 0);
    rst_n = 1;
    check(cmd_ready === 1'b0, "R1 ready low during recall", cmd_ready, 0);
    @(negedge clk);
    check(tap_at(BOOT), "R1 tap after recall", tap_sel[BOOT], 1);
    fetch(3'd0, 0, v);
    check(v == BOOT, "R1 recalled position", v, BOOT);
    m_wpos = BOOT;

    // R2 immediate visibility
    issue(3'd1, 0, 10'h2A5);
    fetch(3'd0, 0, v);
    check(v == 10'h2A5, "R2 position readback", v, 10'h2A5);
    repeat (WD + 2) @(negedge clk);

    // R3 exact tap delay
    issue(3'd1, 0, 10'h0F0);
    cnt = 0;
    for (int i = 0; i < WD; i++) begin
      if (tap_at(10'h2A5)) cnt++;
      @(negedge clk);
    end
    check(cnt == WD, "R3 old tap held", cnt, WD);
    check(tap_at(10'h0F0), "R3 tap switched", tap_sel[10'h0F0], 1);
    // R3 restart
    issue(3'd1, 0, 10'h011);
    repeat (2) @(negedge clk);
    issue(3'd1, 0, 10'h022);
    cnt = 0;
    for (int i = 0; i < WD; i++) begin
      if (tap_at(10'h0F0)) cnt++;
      @(negedge clk);
    end
    check(cnt == WD, "R3 window restarted", cnt, WD);
    check(tap_at(10'h022), "R3 latest value shown", tap_sel[10'h022], 1);

    // R9 ends
    issue(3'd1, 0, 10'h000);
    repeat (WD) @(negedge clk);
    check(tap_at(10'h000), "R9 low end", tap_sel[0], 1);
    issue(3'd1, 0, 10'h3FF);
    repeat (WD) @(negedge clk);
    check(tap_at(10'h3FF), "R9 high end", tap_sel[1023], 1);

    // R5 busy window length
    issue(3'd3, 1, 10'h0AB);
    cnt = 0;
    for (int i = 0; i < NV; i++) begin
      if (nv_busy) cnt++;
      @(negedge clk);
    end
    check(cnt == NV, "R5 busy cycles", cnt, NV);
    check(!nv_busy, "R5 busy falls", nv_busy, 0);
    fetch(3'd2, 1, v);
    check(v == 10'h0AB, "R5 stored value", v, 10'h0AB);
    m_slot[1] = 10'h0AB;

    // R8 R10 R7 during busy
    issue(3'd3, 2, 10'h3C3);
    fetch(3'd2, 2, v);
    check(v == 10'h000, "R8 old value during busy", v, 0);
    fetch(3'd6, 0, v);
    check(v == 10'h001, "R10 busy status high", v, 1);
    issue(3'd1, 0, 10'h123);
    fetch(3'd0, 0, v);
    check(v == 10'h123, "R8 position load during busy", v, 10'h123);
    issue(3'd3, 2, 10'h111);
    wait_idle();
    fetch(3'd2, 2, v);
    check(v == 10'h3C3, "R7 busy store ignored", v, 10'h3C3);
    fetch(3'd6, 0, v);
    check(v == 10'h000, "R10 busy status low", v, 0);
    m_slot[2] = 10'h3C3;

    // R4 both transfer directions
    issue(3'd1, 0, 10'h2F0);
    issue(3'd5, 3, 0);
    wait_idle();
    fetch(3'd2, 3, v);
    check(v == 10'h2F0, "R4 position to setting", v, 10'h2F0);
    issue(3'd1, 0, 10'h000);
    issue(3'd4, 3, 0);
    fetch(3'd0, 0, v);
    check(v == 10'h2F0, "R4 setting to position", v, 10'h2F0);
    repeat (WD) @(negedge clk);
    check(tap_at(10'h2F0), "R4 tap follows transfer", tap_sel[10'h2F0], 1);
    m_slot[3] = 10'h2F0;

    // R6 protect
    store_en = 0;
    issue(3'd3, 1, 10'h3FF);
    check(!nv_busy, "R6 blocked store no busy", nv_busy, 0);
    issue(3'd5, 0, 0);
    check(!nv_busy, "R6 blocked transfer no busy", nv_busy, 0);
    store_en = 1;
    fetch(3'd2, 1, v);
    check(v == 10'h0AB, "R6 setting unchanged", v, 10'h0AB);
    fetch(3'd2, 0, v);
    check(v == BOOT, "R6 setting 0 unchanged", v, BOOT);

    // commit-edge overlap: read on commit edge
    issue(3'd3, 0, 10'h0C0);
    repeat (NV - 1) @(negedge clk);
    fetch(3'd2, 0, v);
    check(v == BOOT, "R5 read on commit edge old", v, BOOT);
    fetch(3'd2, 0, v);
    check(v == 10'h0C0, "R5 read after commit new", v, 10'h0C0);
    m_slot[0] = 10'h0C0;
    // store on commit edge
    issue(3'd3, 1, 10'h044);
    repeat (NV - 1) @(negedge clk);
    issue(3'd3, 1, 10'h3EE);
    check(!nv_busy, "R7 commit-edge store no busy", nv_busy, 0);
    fetch(3'd2, 1, v);
    check(v == 10'h044, "R7 commit-edge store dropped", v, 10'h044);
    m_slot[1] = 10'h044;

    // R11 back-pressure
    issue(3'd0, 0, 0);
    v = rsp_data;
    cnt = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (rsp_valid && rsp_data == v && !cmd_ready) cnt++;
    end
    check(cnt == 3, "R11 response held", cnt, 3);
    check(v == 10'h2F0, "R11 held data", v, 10'h2F0);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    check(!rsp_valid && cmd_ready, "R11 released", rsp_valid, 0);
    m_wpos = 10'h2F0;

    // random mix
    for (int it = 0; it < 80; it++) begin
      logic [2:0] op;
      logic [1:0] sel;
      logic [9:0] d;
      op = 3'($urandom % 7);
      sel = 2'($urandom % 4);
      d = 10'($urandom % 1024);
      store_en = ($urandom % 4) != 0;
      case (op)
        3'd0, 3'd2: begin
          fetch(op, sel, v);
          check(v == model_read(op, sel), "R8 random read", v, model_read(op, sel));
        end
        3'd6: begin
          fetch(op, sel, v);
          check(v == 10'h000, "R10 random status", v, 0);
        end
        3'd1, 3'd4: begin
          m_wpos = (op == 3'd1) ? d : m_slot[sel];
          issue(op, sel, d);
          repeat (WD) @(negedge clk);
          check(tap_at(m_wpos), "R3 random tap", tap_sel[m_wpos], 1);
        end
        default: begin
          if (store_en) m_slot[sel] = (op == 3'd3) ? d : m_wpos;
          issue(op, sel, d);
          check(nv_busy == store_en, "R6 random busy", nv_busy, store_en);
          wait_idle();
          @(negedge clk);
        end
      endcase
    end
    store_en = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule